// File: doc/BRIEF.md
# Dual Periodic Wakeup Timer

This block runs two independent up-counters off a slow tick strobe. Each counter has its own programmable period. The wakeup counter sets a sticky event flag, and that flag drives a level interrupt request. The periodic-reset counter sets its own sticky flag and also sends out a one-cycle reset request. Software sees the block through a four-address byte register interface:

- address 0 holds the event flags and their write-one acknowledges,
- addresses 1 and 2 hold the two periods,
- address 3 is a status byte whose page-select bit picks which counter's live value is returned.

A debug-freeze input stops both counters. The block has three reset domains:

- a system reset clears only the counters,
- a power-on reset that marks a stop-mode exit also clears only the counters, and records the stop exit on an output flag,
- a cold power-on reset clears everything.

The flags and programmed values therefore survive the very reset that the block itself requested.

Top module: `dual_wake_timer`

## Requirements
- R1: Address 3 reads as {page, 0, count[5:0]}. Page is bit 7 and is read/write. Bit 6 always reads 0. Count shows the wakeup counter when page is 0 and the periodic-reset counter when page is 1.
- R2: A read (rd_en high for one clock) loads rdata at that clock edge with the value of the addressed register. rdata then holds that value until the next read, even while the counters keep moving.
- R3: On each tick with freeze low, a counter with a nonzero period p increments. On the tick where count+1 reaches p, it wraps to 0 and expires. So it expires once every p ticks and reads 0 right after an expiry.
- R4: A period of 0 holds its counter at 0 and produces no events.
- R5: A wakeup expiry sets the wakeup flag (address 0 bit 0). The irq output is high exactly while that flag is set.
- R6: A periodic-reset expiry sets the reset flag (address 0 bit 1). It also raises rst_req for exactly one clock, in the cycle after the expiring tick.
- R7: Writing address 0 with bit 4 set clears the wakeup flag. Writing it with bit 5 set clears the reset flag. Writing 0 to those bits has no effect. Bits 7:2 of address 0 always read 0.
- R8: If an expiry and an acknowledge of the same flag arrive in the same clock, the flag stays set.
- R9: While freeze is high, both counters hold their value whatever the tick does. Counting resumes when freeze falls.
- R10: A system reset (rst_n low), or a power-on reset with stop_exit high, clears only the counters. The periods, the page bit and the flags keep their values. A power-on reset with stop_exit low clears all of them.
- R11: stop_exit_por is 1 after a power-on reset taken with stop_exit high and 0 after one taken with stop_exit low. A system reset does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| stop_exit | input | 1 | Qualifies por_n as a stop-mode exit; held stable across the reset |
| rst_n | input | 1 | System reset, active low, asynchronous |
| tick | input | 1 | Slow count strobe, one clock wide per tick |
| freeze | input | 1 | Debug freeze; holds both counters |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 events, 1 wakeup period, 2 reset period, 3 status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, loaded on a read |
| irq | output | 1 | Wakeup interrupt request, level |
| rst_req | output | 1 | Periodic reset request, one-cycle pulse |
| stop_exit_por | output | 1 | Last power-on reset was a stop-mode exit |

## Verification
The bench sweeps every period from 1 to 63 on both counters and compares the count left after a run of ticks against the tick count modulo the period. This catches an off-by-one compare, which would show the wrong residue or miss an expiry. It also counts rst_req pulses against the expected number of expiries, so a pulse held for two cycles or dropped shows up as a wrong total. Further checks cover the following:

- A held status value that a lazy read path would refresh without a read.
- An acknowledge landing in the same clock as an expiry, which a wrong priority would lose.
- A frozen counter that keeps counting.
- The three reset flavours: a design that tied the page bit, periods or flags to the system reset would clear them, and one that mixed up the POR qualifier would report the wrong stop_exit_por.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

  typedef enum logic [1:0] {
    A_EVT  = 2'd0,
    A_WPER = 2'd1,
    A_RPER = 2'd2,
    A_STAT = 2'd3
  } dwt_addr_e;

  localparam int unsigned NCNT     = 2;  // 0: wakeup, 1: periodic reset
  localparam int unsigned ACK_LSB  = 4;  // ack bit for counter g is ACK_LSB+g
  localparam int unsigned PAGE_BIT = 7;
  localparam int unsigned STAT_W   = 6;

endpackage

// File: rtl/dwt_rst_sync.sv
module dwt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic raw_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge raw_ni) begin
    if (!raw_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/dwt_counter.sv
module dwt_counter #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         freeze_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   cnt_inc;
  logic         step, off;

  always_comb begin
    off      = (period_i == '0);
    step     = tick_i && !freeze_i && !off;
    cnt_inc  = {1'b0, cnt_q} + 1'b1;
    expire_o = step && (cnt_inc >= {1'b0, period_i});
    cnt_d    = cnt_q;
    if (off)           cnt_d = '0;
    else if (expire_o) cnt_d = '0;
    else if (step)     cnt_d = cnt_inc[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    expire_o |=> (cnt_q == '0));
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    (period_i == '0) |=> (cnt_q == '0));
  a_r9_freeze_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (freeze_i && period_i != '0) |=> $stable(cnt_q));

endmodule

// File: rtl/dwt_flag.sv
module dwt_flag (
  input  logic clk,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic flag_o
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (ack_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;  // an expiry outranks a same-cycle ack
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_ni)
    set_i |=> flag_o);
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/dual_wake_timer.sv
module dual_wake_timer
  import dwt_pkg::*;
#(
  parameter int unsigned CNT_W       = 6,  // at most STAT_W
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       stop_exit,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       freeze,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       rst_req,
  output logic       stop_exit_por
);

  localparam int unsigned NRST = 3;

  // reset domains: 0 any reset, 1 cold power-on only, 2 any power-on
  logic [NRST-1:0] raw_n, sync_n;
  logic any_rn, cold_rn, por_rn;

  assign raw_n[0] = por_n & rst_n;
  assign raw_n[1] = por_n | stop_exit;
  assign raw_n[2] = por_n;

  for (genvar r = 0; r < NRST; r++) begin : g_rst
    dwt_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .raw_ni (raw_n[r]),
      .rst_no (sync_n[r])
    );
  end

  assign any_rn  = sync_n[0];
  assign cold_rn = sync_n[1];
  assign por_rn  = sync_n[2];

  // programmed state (cold domain)
  logic [CNT_W-1:0] period_q [NCNT];
  logic [CNT_W-1:0] period_d [NCNT];
  logic             page_q, page_d;

  // per-counter datapath
  logic [CNT_W-1:0] cnt [NCNT];
  logic [NCNT-1:0]  expire, flag, ack;

  for (genvar g = 0; g < NCNT; g++) begin : g_ch
    assign ack[g] = wr_en && (dwt_addr_e'(addr) == A_EVT) && wdata[ACK_LSB+g];

    dwt_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_ni   (any_rn),
      .tick_i   (tick),
      .freeze_i (freeze),
      .period_i (period_q[g]),
      .cnt_o    (cnt[g]),
      .expire_o (expire[g])
    );

    dwt_flag u_flag (
      .clk    (clk),
      .rst_ni (cold_rn),
      .set_i  (expire[g]),
      .ack_i  (ack[g]),
      .flag_o (flag[g])
    );
  end

  // register writes
  always_comb begin
    period_d[0] = period_q[0];
    period_d[1] = period_q[1];
    page_d      = page_q;
    if (wr_en) begin
      case (dwt_addr_e'(addr))
        A_WPER:  period_d[0] = wdata[CNT_W-1:0];
        A_RPER:  period_d[1] = wdata[CNT_W-1:0];
        A_STAT:  page_d      = wdata[PAGE_BIT];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge cold_rn) begin
    if (!cold_rn) begin
      period_q[0] <= '0;
      period_q[1] <= '0;
      page_q      <= 1'b0;
    end else begin
      period_q[0] <= period_d[0];
      period_q[1] <= period_d[1];
      page_q      <= page_d;
    end
  end

  // read path: value captured at the read strobe
  logic [STAT_W-1:0] sel_cnt, per_ext;
  logic [7:0]        rdata_q, rdata_d;

  always_comb begin
    sel_cnt = '0;
    sel_cnt[CNT_W-1:0] = page_q ? cnt[1] : cnt[0];
    per_ext = '0;
    rdata_d = rdata_q;
    if (rd_en) begin
      case (dwt_addr_e'(addr))
        A_EVT:  rdata_d = {6'b0, flag[1], flag[0]};
        A_WPER: begin per_ext[CNT_W-1:0] = period_q[0]; rdata_d = {2'b0, per_ext}; end
        A_RPER: begin per_ext[CNT_W-1:0] = period_q[1]; rdata_d = {2'b0, per_ext}; end
        A_STAT: rdata_d = {page_q, 1'b0, sel_cnt};
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge any_rn) begin
    if (!any_rn) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // request outputs
  logic rst_req_q;

  always_ff @(posedge clk or negedge any_rn) begin
    if (!any_rn) rst_req_q <= 1'b0;
    else         rst_req_q <= expire[1];
  end

  assign rst_req = rst_req_q;
  assign irq     = flag[0];

  // power-on origin capture
  logic por_seen_q, warm_q;

  always_ff @(posedge clk or negedge por_rn) begin
    if (!por_rn) por_seen_q <= 1'b0;
    else         por_seen_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge cold_rn) begin
    if (!cold_rn)         warm_q <= 1'b0;
    else if (!por_seen_q) warm_q <= stop_exit;
  end

  assign stop_exit_por = warm_q;

  a_r6_req_has_flag: assert property (@(posedge clk) disable iff (!any_rn)
    rst_req |-> flag[1]);
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!any_rn)
    !rd_en |=> $stable(rdata));
  a_r1_gap_bit_zero: assert property (@(posedge clk) disable iff (!any_rn)
    (rd_en && addr == 2'd3) |=> (rdata[6] == 1'b0));

endmodule

// File: tb/dual_wake_timer_bench.sv
module dual_wake_timer_bench;

  logic       clk = 1'b0;
  logic       por_n, stop_exit, rst_n, tick, freeze, rd_en, wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq, rst_req, stop_exit_por;

  int total = 0;
  int bad   = 0;
  int pulses = 0;

  always #2 clk = ~clk;

  dual_wake_timer u_dual_wake_timer (
    .clk(clk), .por_n(por_n), .stop_exit(stop_exit), .rst_n(rst_n),
    .tick(tick), .freeze(freeze), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
    .rst_req(rst_req), .stop_exit_por(stop_exit_por)
  );

  always @(posedge clk) if (rst_req) pulses++;

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = 8'h00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic por(input logic warm);
    @(negedge clk);
    stop_exit = warm; por_n = 1'b0;
    idle(3);
    por_n = 1'b1;
    idle(5);
    stop_exit = 1'b0;
    idle(1);
  endtask

  task automatic sysrst();
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(5);
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int p0;
    por_n = 1'b0; stop_exit = 1'b0; rst_n = 1'b1; tick = 1'b0; freeze = 1'b0;
    rd_en = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
    idle(4);
    por_n = 1'b1;
    idle(6);

    // reset state (R10, R11, R5)
    chk("R5 irq after cold reset", irq, 0);
    chk("R6 rst_req after cold reset", rst_req, 0);
    chk("R11 stop_exit_por after cold reset", stop_exit_por, 0);
    rd(2'd3, d); chk("R10 status after cold reset", d, 0);
    rd(2'd0, d); chk("R10 events after cold reset", d, 0);
    rd(2'd1, d); chk("R10 wake period after cold reset", d, 0);

    // wakeup counter sweep (R1, R3, R5, R7)
    for (int p = 1; p < 64; p++) begin
      wr(2'd1, 8'd0);
      wr(2'd1, 8'(p));
      ticks(p + 2);
      rd(2'd3, d); chk("R1 R3 wake residue", d, (p + 2) % p);
      chk("R5 irq after wake expiry", irq, 1);
      rd(2'd0, d); chk("R5 wake flag bit", d, 1);
      wr(2'd0, 8'h10);
      chk("R7 irq after wake ack", irq, 0);
    end
    wr(2'd1, 8'd0);

    // periodic reset sweep with page 1 (R1, R3, R6, R7)
    wr(2'd3, 8'h80);
    for (int p = 1; p < 64; p++) begin
      wr(2'd2, 8'd0);
      wr(2'd2, 8'(p));
      p0 = pulses;
      ticks(p + 1);
      rd(2'd3, d); chk("R1 R3 reset residue page1", d, 8'h80 | ((p + 1) % p));
      chk("R6 rst_req pulse count", pulses - p0, (p + 1) / p);
      rd(2'd0, d); chk("R6 reset flag bit", d, 2);
      wr(2'd0, 8'h20);
      rd(2'd0, d); chk("R7 reset flag after ack", d, 0);
    end
    wr(2'd2, 8'd0);
    wr(2'd3, 8'h00);

    // capture and hold (R2)
    wr(2'd1, 8'd40);
    ticks(5);
    rd(2'd3, d); chk("R2 capture", d, 5);
    ticks(3);
    chk("R2 hold without read", rdata, 5);
    rd(2'd3, d); chk("R2 recapture", d, 8);
    wr(2'd3, 8'hFF);
    rd(2'd3, d); chk("R1 bit6 zero and page 1", d, 8'h80);
    wr(2'd3, 8'h00);

    // freeze (R9)
    freeze = 1'b1;
    ticks(10);
    rd(2'd3, d); chk("R9 frozen count", d, 8);
    freeze = 1'b0;
    ticks(2);
    rd(2'd3, d); chk("R9 resumed count", d, 10);

    // period zero (R4)
    wr(2'd1, 8'd0);
    ticks(70);
    rd(2'd3, d); chk("R4 count held zero", d, 0);
    chk("R4 no irq", irq, 0);
    rd(2'd0, d); chk("R4 no flags", d, 0);

    // ack write of zero, ack bits read zero (R7)
    wr(2'd1, 8'd2);
    ticks(2);
    wr(2'd0, 8'h00);
    chk("R7 zero write keeps irq", irq, 1);
    wr(2'd0, 8'hCF);
    rd(2'd0, d); chk("R7 acks read zero, flag kept", d, 1);

    // expiry and ack in the same clock (R8)
    wr(2'd1, 8'd1);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 8'h10;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0; wdata = 8'h00;
    chk("R8 flag survives same-cycle ack", irq, 1);
    wr(2'd0, 8'h10);
    chk("R8 flag clears on lone ack", irq, 0);

    // reset domains (R10, R11)
    wr(2'd1, 8'd5);
    wr(2'd2, 8'd7);
    wr(2'd3, 8'h80);
    ticks(6);
    rd(2'd3, d); chk("R3 reset counter before sysrst", d, 8'h86);
    sysrst();
    rd(2'd3, d); chk("R10 sysrst keeps page, clears count", d, 8'h80);
    rd(2'd1, d); chk("R10 sysrst keeps wake period", d, 5);
    rd(2'd2, d); chk("R10 sysrst keeps reset period", d, 7);
    rd(2'd0, d); chk("R10 sysrst keeps flag", d, 1);
    chk("R11 sysrst after cold", stop_exit_por, 0);

    por(1'b1);
    chk("R11 warm por flag", stop_exit_por, 1);
    rd(2'd3, d); chk("R10 warm por keeps page", d, 8'h80);
    rd(2'd1, d); chk("R10 warm por keeps period", d, 5);
    chk("R10 warm por keeps irq", irq, 1);
    sysrst();
    chk("R11 sysrst keeps warm flag", stop_exit_por, 1);

    por(1'b0);
    chk("R11 cold por flag", stop_exit_por, 0);
    rd(2'd3, d); chk("R10 cold por clears page", d, 0);
    rd(2'd1, d); chk("R10 cold por clears period", d, 0);
    rd(2'd0, d); chk("R10 cold por clears flags", d, 0);
    chk("R10 cold por irq", irq, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule